// File: doc/BRIEF.md
# Shift-Add CORDIC Eight-Point DCT Core

This core turns eight parallel signed samples into eight unscaled, approximate DCT coefficients in one combinational pass. It holds no registers. The structure is a butterfly network of the fast-DCT kind. The three nontrivial plane rotations are replaced by short fixed chains of CORDIC microrotations. Each microrotation needs only an arithmetic right shift and an add or subtract per coordinate, so the core has no multipliers.

The per-coefficient scale factors are left out and are expected to be folded into a later quantizer. The two odd-part rotations use the same shift magnitudes, so they share one scale factor. One stage-5 negation is folded into the adder that follows it. The other negation is, by default, a bitwise inversion, which shortens the longest path to six adders plus one inverter.

The core is meant as the row or column kernel of a larger 2-D transform that supplies its own pipelining.

Top module: `cordic_dct8`

## Requirements
- R1: Sample n sits at bits [n*12 +: 12] of `samples` and coefficient n at bits [n*16 +: 16] of `coefs`, all in two's complement. Coefficient 0 equals the sum of all eight samples.
- R2: With a_i = s_i + s_(7-i) and b_i = s_i - s_(7-i) for i = 0..3, and c0 = a0+a3, c1 = a1+a2, coefficient 4 equals c0 - c1.
- R3: Coefficients 2 and 6 are the x and y results of rotating (c3 = a0-a3, c2 = a1-a2) through two microrotations. The shifts are 1 then 4, and both use positive sign.
- R4: A microrotation with shift k and sign s maps (x, y) to (x - s*(y>>>k), y + s*(x>>>k)), using the old x and y in both terms. The odd part rotates (b0, b3) into (p0, p1) with shifts 1, 2, 4 and signs +, -, +. It rotates (b1, b2) into (q0, q1) with the same shifts and signs -, +, -.
- R5: With u0 = p0+q1, u1 = p0-q1, u2 = p1+q0 and u3 = p1-q0, coefficient 1 is u0+u2, coefficient 7 is u2-u0 and coefficient 3 is u1+u3.
- R6: Coefficient 5 is u1-u3 when EXACT_NEG=1. It is u1-u3-1, the bitwise inversion of u3-u1, when EXACT_NEG=0.
- R7: No coefficient overflows 16 bits for any 12-bit input. This includes full-scale values of opposite sign on the two halves of the input vector.
- R8: When all eight samples are equal to v, coefficient 0 is 8v and every other coefficient is 0. The one exception is coefficient 5 in inversion mode, which is -1.
- R9: The outputs depend only on the present inputs. Applying a vector again after others gives the same coefficients.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| samples | input | 96 | Eight packed 12-bit signed samples, sample n at [n*12 +: 12] |
| coefs | output | 128 | Eight packed 16-bit signed coefficients, coefficient n at [n*16 +: 16] |

## Verification
Every coefficient is a purely combinational function of `samples`, so each result is due in the same cycle as the stimulus, with no register stage in between. The bench changes the inputs just after a rising clock edge and reads all eight coefficients at the following falling edge. This leaves half a period for the adder chain to settle and keeps every check clear of the edge. Two instances, one per negation mode, are checked against a bit-exact integer model of the same shift-add graph.

// File: rtl/cdct_pkg.sv
package cdct_pkg;

    // Rotation chains: stage k uses shift [k*4 +: 4] and negative sign if bit k set
    localparam int          ROT_EVEN_N   = 2;
    localparam logic [7:0]  ROT_EVEN_SH  = {4'd4, 4'd1};
    localparam logic [1:0]  ROT_EVEN_NEG = 2'b00;

    localparam int          ROT_ODD_N    = 3;
    localparam logic [11:0] ROT_ODD_SH   = {4'd4, 4'd2, 4'd1};
    localparam logic [2:0]  ROT_HI_NEG   = 3'b010;   // +, -, +
    localparam logic [2:0]  ROT_LO_NEG   = 3'b101;   // -, +, -

    localparam int NUM_PTS = 8;
    localparam int HALF    = NUM_PTS / 2;

endpackage

// File: rtl/cdct_microrot.sv
module cdct_microrot #(
    parameter int   W   = 18,
    parameter int   SH  = 1,
    parameter logic NEG = 1'b0
) (
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] y_i,
    output logic signed [W-1:0] x_o,
    output logic signed [W-1:0] y_o
);
    logic signed [W-1:0] xs_d, ys_d;

    always_comb begin
        xs_d = x_i >>> SH;
        ys_d = y_i >>> SH;
    end

    generate
        if (NEG) begin : g_neg
            always_comb begin
                x_o = x_i + ys_d;
                y_o = y_i - xs_d;
            end
        end else begin : g_pos
            always_comb begin
                x_o = x_i - ys_d;
                y_o = y_i + xs_d;
            end
        end
    endgenerate
endmodule

// File: rtl/cdct_rotator.sv
module cdct_rotator #(
    parameter int             W      = 18,
    parameter int             N      = 3,
    parameter logic [4*N-1:0] SHIFTS = '0,
    parameter logic [N-1:0]   SIGNS  = '0
) (
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] y_i,
    output logic signed [W-1:0] x_o,
    output logic signed [W-1:0] y_o
);
    logic signed [W-1:0] xc [N+1];
    logic signed [W-1:0] yc [N+1];

    assign xc[0] = x_i;
    assign yc[0] = y_i;

    generate
        for (genvar k = 0; k < N; k++) begin : g_stage
            cdct_microrot #(
                .W   (W),
                .SH  (int'(SHIFTS[k*4 +: 4])),
                .NEG (SIGNS[k])
            ) u_mr (
                .x_i (xc[k]),
                .y_i (yc[k]),
                .x_o (xc[k+1]),
                .y_o (yc[k+1])
            );
        end
    endgenerate

    assign x_o = xc[N];
    assign y_o = yc[N];
endmodule

// File: rtl/cdct_even.sv
module cdct_even #(
    parameter int W = 18
) (
    input  logic signed [W-1:0] a0,
    input  logic signed [W-1:0] a1,
    input  logic signed [W-1:0] a2,
    input  logic signed [W-1:0] a3,
    output logic signed [W-1:0] k0,
    output logic signed [W-1:0] k4,
    output logic signed [W-1:0] k2,
    output logic signed [W-1:0] k6
);
    import cdct_pkg::*;

    logic signed [W-1:0] c0_d, c1_d, c2_d, c3_d;

    always_comb begin
        c0_d = a0 + a3;
        c1_d = a1 + a2;
        c2_d = a1 - a2;
        c3_d = a0 - a3;
        k0   = c0_d + c1_d;
        k4   = c0_d - c1_d;
    end

    cdct_rotator #(
        .W      (W),
        .N      (ROT_EVEN_N),
        .SHIFTS (ROT_EVEN_SH),
        .SIGNS  (ROT_EVEN_NEG)
    ) u_rot_even (
        .x_i (c3_d),
        .y_i (c2_d),
        .x_o (k2),
        .y_o (k6)
    );
endmodule

// File: rtl/cdct_odd.sv
module cdct_odd #(
    parameter int   W         = 18,
    parameter logic EXACT_NEG = 1'b0
) (
    input  logic signed [W-1:0] b0,
    input  logic signed [W-1:0] b1,
    input  logic signed [W-1:0] b2,
    input  logic signed [W-1:0] b3,
    output logic signed [W-1:0] k1,
    output logic signed [W-1:0] k5,
    output logic signed [W-1:0] k3,
    output logic signed [W-1:0] k7
);
    import cdct_pkg::*;

    logic signed [W-1:0] p0, p1, q0, q1;
    logic signed [W-1:0] u0_d, u1_d, u2_d, u3_d, w_d;

    cdct_rotator #(
        .W      (W),
        .N      (ROT_ODD_N),
        .SHIFTS (ROT_ODD_SH),
        .SIGNS  (ROT_HI_NEG)
    ) u_rot_hi (
        .x_i (b0),
        .y_i (b3),
        .x_o (p0),
        .y_o (p1)
    );

    cdct_rotator #(
        .W      (W),
        .N      (ROT_ODD_N),
        .SHIFTS (ROT_ODD_SH),
        .SIGNS  (ROT_LO_NEG)
    ) u_rot_lo (
        .x_i (b1),
        .y_i (b2),
        .x_o (q0),
        .y_o (q1)
    );

    always_comb begin
        u0_d = p0 + q1;
        u1_d = p0 - q1;
        u2_d = p1 + q0;
        u3_d = p1 - q0;
        k1   = u0_d + u2_d;
        k7   = u2_d - u0_d;   // negation folded into this subtractor
        k3   = u1_d + u3_d;
        w_d  = u3_d - u1_d;
    end

    generate
        if (EXACT_NEG) begin : g_exact
            assign k5 = -w_d;
        end else begin : g_inv
            assign k5 = ~w_d;
        end
    endgenerate
endmodule

// File: rtl/cordic_dct8.sv
module cordic_dct8 #(
    parameter int   IN_W      = 12,
    parameter int   OUT_W     = 16,
    parameter logic EXACT_NEG = 1'b0
) (
    input  logic [8*IN_W-1:0]  samples,
    output logic [8*OUT_W-1:0] coefs
);
    import cdct_pkg::*;

    localparam int IW = OUT_W + 2;

    logic signed [IW-1:0] s_d  [NUM_PTS];
    logic signed [IW-1:0] a_d  [HALF];
    logic signed [IW-1:0] b_d  [HALF];
    logic signed [IW-1:0] kc_d [NUM_PTS];

    generate
        for (genvar n = 0; n < NUM_PTS; n++) begin : g_unpack
            assign s_d[n] = IW'($signed(samples[n*IN_W +: IN_W]));
            assign coefs[n*OUT_W +: OUT_W] = kc_d[n][OUT_W-1:0];
        end
        for (genvar i = 0; i < HALF; i++) begin : g_bfly
            assign a_d[i] = s_d[i] + s_d[NUM_PTS-1-i];
            assign b_d[i] = s_d[i] - s_d[NUM_PTS-1-i];
        end
    endgenerate

    cdct_even #(.W(IW)) u_even (
        .a0 (a_d[0]), .a1 (a_d[1]), .a2 (a_d[2]), .a3 (a_d[3]),
        .k0 (kc_d[0]), .k4 (kc_d[4]), .k2 (kc_d[2]), .k6 (kc_d[6])
    );

    cdct_odd #(.W(IW), .EXACT_NEG(EXACT_NEG)) u_odd (
        .b0 (b_d[0]), .b1 (b_d[1]), .b2 (b_d[2]), .b3 (b_d[3]),
        .k1 (kc_d[1]), .k5 (kc_d[5]), .k3 (kc_d[3]), .k7 (kc_d[7])
    );

    // Checks on the settled combinational network
    logic                 all_eq;
    logic signed [IW-1:0] in_sum;
    always_comb begin
        all_eq = 1'b1;
        in_sum = '0;
        for (int n = 0; n < NUM_PTS; n++) begin
            in_sum = in_sum + s_d[n];
            if (s_d[n] != s_d[0]) all_eq = 1'b0;
        end
        for (int n = 0; n < NUM_PTS; n++) begin
            AST_NO_OVERFLOW: assert (kc_d[n] == IW'($signed(kc_d[n][OUT_W-1:0])))
                else $error("coefficient %0d exceeds output width", n); // R7
        end
        AST_DC_SUM: assert ($signed(coefs[OUT_W-1:0]) == in_sum[OUT_W-1:0])
            else $error("coefficient 0 differs from input sum"); // R1
        if (all_eq) begin
            AST_DC_EVEN_ZERO: assert (kc_d[2] == '0 && kc_d[4] == '0 && kc_d[6] == '0)
                else $error("even AC term nonzero for flat input"); // R8
            AST_DC_ODD_ZERO: assert (kc_d[1] == '0 && kc_d[3] == '0 && kc_d[7] == '0)
                else $error("odd AC term nonzero for flat input"); // R8
            AST_DC_NEG_MODE: assert (kc_d[5] == (EXACT_NEG ? IW'(0) : IW'(-1)))
                else $error("coefficient 5 wrong for flat input"); // R6
        end
    end
endmodule

// File: tb/cordic_dct8_test.sv
module cordic_dct8_test;
    localparam int PERIOD = 10;
    localparam int IN_W   = 12;
    localparam int OUT_W  = 16;
    localparam int NVEC   = 6;

    localparam int VEC_TABLE [NVEC][8] = '{
        '{   1,   2,   3,   4,   5,   6,   7,   8 },
        '{ 100, -50, 300,  -7,  12, 900,-1000, 33 },
        '{2047,-2048,2047,-2048,2047,-2048,2047,-2048},
        '{2047,2047,2047,2047,-2048,-2048,-2048,-2048},
        '{-2048,2047,-2048,2047,2047,-2048,2047,-2048},
        '{   0,   0,   0, 1500,   0,   0,   0,   0 }
    };

    logic clk = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    logic [8*IN_W-1:0]  samples;
    logic [8*OUT_W-1:0] coefs_x, coefs_i;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    cordic_dct8 #(.IN_W(IN_W), .OUT_W(OUT_W), .EXACT_NEG(1'b1)) uut (
        .samples (samples), .coefs (coefs_x));
    cordic_dct8 #(.IN_W(IN_W), .OUT_W(OUT_W), .EXACT_NEG(1'b0)) uut_inv (
        .samples (samples), .coefs (coefs_i));

    // Integer model of the shift-add graph (R4 microrotation)
    task automatic mrot(inout int x, inout int y, input int sh, input bit neg);
        int xs = x >>> sh;
        int ys = y >>> sh;
        if (neg) begin x = x + ys; y = y - xs; end
        else     begin x = x - ys; y = y + xs; end
    endtask

    task automatic model(input int s[8], input bit exact, output int r[8]);
        int a[4], b[4];
        int c0, c1, c2, c3, p0, p1, q0, q1, u0, u1, u2, u3;
        for (int i = 0; i < 4; i++) begin
            a[i] = s[i] + s[7-i];
            b[i] = s[i] - s[7-i];
        end
        c0 = a[0] + a[3]; c1 = a[1] + a[2];
        c2 = a[1] - a[2]; c3 = a[0] - a[3];
        r[0] = c0 + c1;
        r[4] = c0 - c1;
        mrot(c3, c2, 1, 1'b0); mrot(c3, c2, 4, 1'b0);
        r[2] = c3; r[6] = c2;
        p0 = b[0]; p1 = b[3];
        mrot(p0, p1, 1, 1'b0); mrot(p0, p1, 2, 1'b1); mrot(p0, p1, 4, 1'b0);
        q0 = b[1]; q1 = b[2];
        mrot(q0, q1, 1, 1'b1); mrot(q0, q1, 2, 1'b0); mrot(q0, q1, 4, 1'b1);
        u0 = p0 + q1; u1 = p0 - q1; u2 = p1 + q0; u3 = p1 - q0;
        r[1] = u0 + u2;
        r[7] = u2 - u0;
        r[3] = u1 + u3;
        r[5] = exact ? (u1 - u3) : (u1 - u3 - 1);
    endtask

    function automatic string req_of(int n);
        case (n)
            0: return "R1";
            4: return "R2";
            2, 6: return "R3";
            5: return "R6";
            default: return "R5/R4";
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int coef(logic [8*OUT_W-1:0] v, int n);
        return int'($signed(v[n*OUT_W +: OUT_W]));
    endfunction

    task automatic drive(input int s[8]);
        @(posedge clk);
        for (int n = 0; n < 8; n++) samples[n*IN_W +: IN_W] = IN_W'(s[n]);
        @(negedge clk);
    endtask

    // Result is due the same cycle; sampled at the falling edge
    task automatic apply_and_check(input int s[8]);
        int rx[8], ri[8];
        drive(s);
        model(s, 1'b1, rx);
        model(s, 1'b0, ri);
        for (int n = 0; n < 8; n++) begin
            check({req_of(n), " exact"}, coef(coefs_x, n), rx[n]);
            check({req_of(n), " inv"},   coef(coefs_i, n), ri[n]);
            if (rx[n] > 32767 || rx[n] < -32768 || ri[n] > 32767 || ri[n] < -32768)
                check("R7 range", 1, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int v[8];
        int first_x[8];
        samples = '0;

        // Zero input: all zero, coefficient 5 is -1 in inversion mode (R8, R6)
        @(negedge clk);
        for (int n = 0; n < 8; n++) begin
            check("R8 zero exact", coef(coefs_x, n), 0);
            check("R8 zero inv", coef(coefs_i, n), (n == 5) ? -1 : 0);
        end

        // Table walk
        for (int t = 0; t < NVEC; t++) begin
            for (int n = 0; n < 8; n++) v[n] = VEC_TABLE[t][n];
            apply_and_check(v);
            if (t == 0) for (int n = 0; n < 8; n++) first_x[n] = coef(coefs_x, n);
        end

        // Random vectors
        for (int t = 0; t < 40; t++) begin
            for (int n = 0; n < 8; n++) v[n] = int'($urandom_range(4095)) - 2048;
            apply_and_check(v);
        end

        // Flat inputs (R8) at extremes and mid values
        foreach (v[n]) v[n] = 0;
        for (int t = 0; t < 4; t++) begin
            int lvl = (t == 0) ? 2047 : (t == 1) ? -2048 : (t == 2) ? 5 : -777;
            for (int n = 0; n < 8; n++) v[n] = lvl;
            drive(v);
            check("R8 dc exact", coef(coefs_x, 0), 8 * lvl);
            check("R8 dc inv", coef(coefs_i, 0), 8 * lvl);
            for (int n = 1; n < 8; n++) begin
                check("R8 ac exact", coef(coefs_x, n), 0);
                check("R8 ac inv", coef(coefs_i, n), (n == 5) ? -1 : 0);
            end
        end

        // R9: reapply first table vector, same result
        for (int n = 0; n < 8; n++) v[n] = VEC_TABLE[0][n];
        drive(v);
        for (int n = 0; n < 8; n++) check("R9 repeat", coef(coefs_x, n), first_x[n]);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule